// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a RISC core. It holds one bank of global registers and a ring of overlapping register windows. An instruction names a register with a 5-bit number from 0 to 31. The physical register that number reaches depends on a current-window pointer (CWP). Two combinational read ports and one clocked write port serve three-operand instructions: two sources and one destination in each cycle.

Procedure calls move through the ring with a save request, and returns move back with a restore request. Each window has 8 out registers. They are the same storage as the 8 in registers of the window that a save enters, so arguments pass between caller and callee without any copying. A per-window invalid mask marks windows whose contents live elsewhere. A save or restore that would land on a marked window leaves the pointer in place and raises a one-cycle trap pulse. Spilling and filling windows, and handling the trap, are left to the surrounding core.

Top module: `winreg_file`

## Requirements
- R1: Register number 0 always reads as zero on both read ports, and a write to it has no effect.
- R2: Register numbers 1 to 7 (bits [4:3] = 0) select global registers, which read the same from every window.
- R3: Register numbers 16 to 23 (bits [4:3] = 2) select locals, and 24 to 31 (bits [4:3] = 3) select ins, both private to the current window. In all cases bits [2:0] give the register within its group of eight.
- R4: Register numbers 8 to 15 (bits [4:3] = 1) select the outs of window w. These are the same storage as the ins of window (w-1) mod NWIN, so a value written to out k before a save reads back as in k after it.
- R5: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle on.
- R6: On a clock edge with save_req high, cwp becomes (cwp-1) mod NWIN. With restore_req high and save_req low, cwp becomes (cwp+1) mod NWIN. When both are high, the save is performed and the restore is ignored.
- R7: If the target window of a save has its mask bit set, cwp stays unchanged and spill_trap is high for exactly the cycle after that edge. A blocked restore does the same on fill_trap.
- R8: Synchronous reset sets cwp to 0, sets the mask to have only bit 1 set, and clears both trap outputs. Register contents are not reset.
- R9: When mask_load is high, the mask takes the value of mask_in on the clock edge. A save or restore in the same cycle is tested against the old mask.
- R10: The two read ports select registers independently, each through its own window mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 5 | Register number for read port A |
| rd_a_data | output | DW | Read port A data (combinational) |
| rd_b_sel | input | 5 | Register number for read port B |
| rd_b_data | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Register number to write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to the next window down (call) |
| restore_req | input | 1 | Move to the next window up (return) |
| mask_load | input | 1 | Load a new invalid-window mask |
| mask_in | input | NWIN | New mask, one bit per window |
| cwp | output | $clog2(NWIN) | Current window pointer |
| spill_trap | output | 1 | One-cycle pulse: save blocked by the mask |
| fill_trap | output | 1 | One-cycle pulse: restore blocked by the mask |

## Verification
The hardest situation to reach from the ports is sharing of out and in registers across the wraparound of the ring. A value must be written as an out in window 0 and then read as an in of window NWIN-1, with no trap in between and no mask bit standing in the way. The bench first clears the mask and walks a save through every window, writing every local and in, so that all storage holds known values. It then runs long random stretches in which saves, restores and occasional single-bit mask loads move the pointer around the whole ring. Every read is compared with a reference model that is organised by window. Directed cycles cover the simultaneous save and restore, the mask load in the same cycle as a save, and the read during a write.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int unsigned GLOBALS   = 8;
  localparam int unsigned BANK_REGS = 16;
  localparam int unsigned HALF      = 8;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  function automatic grp_e grp_of(input logic [4:0] sel);
    return grp_e'(sel[4:3]);
  endfunction
endpackage

// File: rtl/winreg_map.sv
// Turns a register number and the window pointer into a physical index.
// Layout: globals at 0..7, then one 16-entry bank per window (locals, ins).
module winreg_map
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [4:0]    sel,
  input  logic [CW-1:0] cwp,
  output logic [PW-1:0] phys
);
  int unsigned off;
  int unsigned cur_base;
  int unsigned prv_base;
  int unsigned idx;

  always_comb begin
    off      = 32'(sel[2:0]);
    cur_base = GLOBALS + 32'(cwp) * BANK_REGS;
    // outs live in the ins half of the neighbour below, with wraparound
    prv_base = (cwp == '0) ? GLOBALS + (NWIN - 1) * BANK_REGS
                           : cur_base - BANK_REGS;
    unique case (grp_of(sel))
      GRP_GLB: idx = off;
      GRP_OUT: idx = prv_base + HALF + off;
      GRP_LOC: idx = cur_base + off;
      default: idx = cur_base + HALF + off;
    endcase
    phys = PW'(idx);
  end
endmodule

// File: rtl/winreg_store.sv
// Physical storage: one synchronous write, two asynchronous reads.
module winreg_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 136,
  parameter int unsigned PW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr_a,
  input  logic [PW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/winreg_wctl.sv
// Window pointer, invalid mask and trap pulses.
module winreg_wctl #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            mask_load,
  input  logic [NWIN-1:0] mask_in,
  output logic [CW-1:0]   cwp_q,
  output logic [NWIN-1:0] mask_q,
  output logic            spill_q,
  output logic            fill_q
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  logic [CW-1:0] dn_ptr;
  logic [CW-1:0] up_ptr;

  assign dn_ptr = (cwp_q == '0)  ? LAST : cwp_q - 1'b1;
  assign up_ptr = (cwp_q == LAST) ? '0  : cwp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp_q   <= '0;
      mask_q  <= NWIN'(2);
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
      if (save_req) begin
        if (mask_q[dn_ptr]) spill_q <= 1'b1;
        else                cwp_q   <= dn_ptr;
      end else if (restore_req) begin
        if (mask_q[up_ptr]) fill_q <= 1'b1;
        else                cwp_q  <= up_ptr;
      end
      if (mask_load) mask_q <= mask_in;
    end
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              rd_a_sel,
  output logic [DW-1:0]           rd_a_data,
  input  logic [4:0]              rd_b_sel,
  output logic [DW-1:0]           rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_sel,
  input  logic [DW-1:0]           wr_data,
  input  logic                    save_req,
  input  logic                    restore_req,
  input  logic                    mask_load,
  input  logic [NWIN-1:0]         mask_in,
  output logic [$clog2(NWIN)-1:0] cwp,
  output logic                    spill_trap,
  output logic                    fill_trap
);
  localparam int unsigned CW    = $clog2(NWIN);
  localparam int unsigned DEPTH = GLOBALS + NWIN * BANK_REGS;
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned NPORT = 3;  // read A, read B, write

  logic [CW-1:0]   cwp_q;
  logic [NWIN-1:0] mask_q;
  logic [4:0]      sel_vec  [NPORT];
  logic [PW-1:0]   phys_vec [NPORT];
  logic [DW-1:0]   raw_a;
  logic [DW-1:0]   raw_b;

  assign sel_vec[0] = rd_a_sel;
  assign sel_vec[1] = rd_b_sel;
  assign sel_vec[2] = wr_sel;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    winreg_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .sel  (sel_vec[p]),
      .cwp  (cwp_q),
      .phys (phys_vec[p])
    );
  end

  winreg_store #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk     (clk),
    .we      (wr_en && (wr_sel != '0)),
    .waddr   (phys_vec[2]),
    .wdata   (wr_data),
    .raddr_a (phys_vec[0]),
    .raddr_b (phys_vec[1]),
    .rdata_a (raw_a),
    .rdata_b (raw_b)
  );

  winreg_wctl #(.NWIN(NWIN), .CW(CW)) u_wctl (
    .clk         (clk),
    .rst         (rst),
    .save_req    (save_req),
    .restore_req (restore_req),
    .mask_load   (mask_load),
    .mask_in     (mask_in),
    .cwp_q       (cwp_q),
    .mask_q      (mask_q),
    .spill_q     (spill_trap),
    .fill_q      (fill_trap)
  );

  assign rd_a_data = (rd_a_sel == '0) ? '0 : raw_a;
  assign rd_b_data = (rd_b_sel == '0) ? '0 : raw_b;
  assign cwp       = cwp_q;
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      rd_a_sel,
  input logic [DW-1:0]   rd_a_data,
  input logic [4:0]      rd_b_sel,
  input logic [DW-1:0]   rd_b_data,
  input logic            wr_en,
  input logic [4:0]      wr_sel,
  input logic [DW-1:0]   wr_data,
  input logic            save_req,
  input logic            restore_req,
  input logic            mask_load,
  input logic [NWIN-1:0] mask_in,
  input logic [CW-1:0]   cwp,
  input logic [NWIN-1:0] mask_q,
  input logic            spill_trap,
  input logic            fill_trap
);
  function automatic int below(input logic [CW-1:0] c);
    return (int'(c) + int'(NWIN) - 1) % int'(NWIN);
  endfunction
  function automatic int above(input logic [CW-1:0] c);
    return (int'(c) + 1) % int'(NWIN);
  endfunction

  a_r1_zero_a: assert property (@(posedge clk) disable iff (rst)
    (rd_a_sel == 5'd0) |-> (rd_a_data == '0));
  a_r1_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rd_b_sel == 5'd0) |-> (rd_b_data == '0));
  a_r5_write_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && ($past(wr_sel) != 5'd0) && ($past(cwp) == cwp)
     && (rd_a_sel == $past(wr_sel))) |-> (rd_a_data == $past(wr_data)));
  a_r6_save_step: assert property (@(posedge clk) disable iff (rst)
    (save_req && !mask_q[below(cwp)]) |=> (int'(cwp) == below($past(cwp))));
  a_r6_restore_step: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_req && !mask_q[above(cwp)])
    |=> (int'(cwp) == above($past(cwp))));
  a_r7_spill_cause: assert property (@(posedge clk) disable iff (rst)
    spill_trap |-> ($past(save_req) && $stable(cwp)));
  a_r7_fill_cause: assert property (@(posedge clk) disable iff (rst)
    fill_trap |-> ($past(restore_req) && !$past(save_req) && $stable(cwp)));
  a_r7_one_trap: assert property (@(posedge clk) disable iff (rst)
    !(spill_trap && fill_trap));
  a_r8_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((cwp == '0) && (mask_q == NWIN'(2)) && !spill_trap && !fill_trap));
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst)
    (int'(cwp) < int'(NWIN)));
  a_r9_mask_load: assert property (@(posedge clk) disable iff (rst)
    mask_load |=> (mask_q == $past(mask_in)));
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .DW(DW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_a_sel    (rd_a_sel),
  .rd_a_data   (rd_a_data),
  .rd_b_sel    (rd_b_sel),
  .rd_b_data   (rd_b_data),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .save_req    (save_req),
  .restore_req (restore_req),
  .mask_load   (mask_load),
  .mask_in     (mask_in),
  .cwp         (cwp),
  .mask_q      (mask_q),
  .spill_trap  (spill_trap),
  .fill_trap   (fill_trap)
);

// File: tb/winreg_file_tb_top.sv
`timescale 1ns/1ps
module winreg_file_tb_top;
  localparam int NW = 8;
  localparam int DW = 32;
  localparam int CWB = $clog2(NW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, mask_load = 1'b0;
  logic [NW-1:0] mask_in = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic [CWB-1:0] cwp;
  logic spill_trap, fill_trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model, organised by window: [0..7] locals, [8..15] ins
  logic [DW-1:0] mg [8];
  logic [DW-1:0] mwin [NW][16];
  int mcwp;
  logic [NW-1:0] mmask;
  logic espill, efill;

  always #10 clk = ~clk;  // 50 MHz

  winreg_file #(.NWIN(NW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .mask_load(mask_load), .mask_in(mask_in),
    .cwp(cwp), .spill_trap(spill_trap), .fill_trap(fill_trap)
  );

  function automatic logic [DW-1:0] mread(input logic [4:0] s, input int w);
    int k = int'(s[2:0]);
    case (s[4:3])
      2'd0:    return (s == 5'd0) ? '0 : mg[k];
      2'd1:    return mwin[(w + NW - 1) % NW][8 + k];
      2'd2:    return mwin[w][k];
      default: return mwin[w][8 + k];
    endcase
  endfunction

  task automatic mwrite(input logic [4:0] s, input int w, input logic [DW-1:0] d);
    int k = int'(s[2:0]);
    case (s[4:3])
      2'd0:    if (s != 5'd0) mg[k] = d;
      2'd1:    mwin[(w + NW - 1) % NW][8 + k] = d;
      2'd2:    mwin[w][k] = d;
      default: mwin[w][8 + k] = d;
    endcase
  endtask

  function automatic string rtag(input logic [4:0] s);
    if (s == 5'd0) return "R1";
    case (s[4:3])
      2'd0:    return "R2";
      2'd1:    return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; mask_load = 1'b0;
  endtask

  // Called just after a falling edge with inputs set.
  task automatic do_cycle(input string rt, input string ct);
    #1;
    chk((rt == "") ? rtag(rd_a_sel) : rt, "rd_a", rd_a_data, mread(rd_a_sel, mcwp));
    chk({"R10 ", rtag(rd_b_sel)}, "rd_b", rd_b_data, mread(rd_b_sel, mcwp));
    @(posedge clk);
    if (wr_en) mwrite(wr_sel, mcwp, wr_data);
    espill = 1'b0;
    efill  = 1'b0;
    if (save_req) begin
      if (mmask[(mcwp + NW - 1) % NW]) espill = 1'b1;
      else mcwp = (mcwp + NW - 1) % NW;
    end else if (restore_req) begin
      if (mmask[(mcwp + 1) % NW]) efill = 1'b1;
      else mcwp = (mcwp + 1) % NW;
    end
    if (mask_load) mmask = mask_in;
    @(negedge clk);
    chk(ct, "cwp", DW'(cwp), DW'(mcwp));
    chk((ct == "R6") ? "R7" : ct, "spill_trap", DW'(spill_trap), DW'(espill));
    chk((ct == "R6") ? "R7" : ct, "fill_trap", DW'(fill_trap), DW'(efill));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    mcwp = 0; mmask = NW'(2); espill = 1'b0; efill = 1'b0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "cwp reset", DW'(cwp), '0);
    chk("R8", "spill reset", DW'(spill_trap), '0);
    chk("R8", "fill reset", DW'(fill_trap), '0);
    chk("R1", "r0 in reset", rd_a_data, '0);
    rst = 1'b0;

    // R8: window 1 marked at reset -> restore from 0 is blocked (R7)
    restore_req = 1'b1; do_cycle("", "R8");
    idle(); do_cycle("", "R7");   // trap lasts one cycle

    // R9: clear mask with a save in the same cycle: tested against old mask
    mask_load = 1'b1; mask_in = '0; save_req = 1'b1; do_cycle("", "R9");
    idle(); restore_req = 1'b1; do_cycle("", "R6");  // back to 0, bit 1 clear now

    // fill every global, local and in of every window
    for (int g = 1; g < 8; g++) begin
      idle(); wr_en = 1'b1; wr_sel = 5'(g); wr_data = $urandom; do_cycle("", "R2");
    end
    for (int w = 0; w < NW; w++) begin
      for (int r = 16; r < 32; r++) begin
        idle(); wr_en = 1'b1; wr_sel = 5'(r); wr_data = $urandom;
        rd_a_sel = 5'(r); do_cycle("", "R3");
      end
      idle(); save_req = 1'b1; do_cycle("", "R6");
    end

    // R1: write to r0 ignored
    idle(); wr_en = 1'b1; wr_sel = 5'd0; wr_data = 32'hdeadbeef; rd_a_sel = 5'd0;
    do_cycle("R1", "R6");
    idle(); do_cycle("R1", "R6");

    // R5: read during write returns old, then new
    idle(); wr_en = 1'b1; wr_sel = 5'd18; wr_data = 32'h1234abcd; rd_a_sel = 5'd18;
    do_cycle("R5", "R6");
    idle(); do_cycle("R5", "R6");

    // R4 across the wrap: out in window 0, save, read as in of window NW-1
    idle(); wr_en = 1'b1; wr_sel = 5'd9; wr_data = 32'h0badf00d; do_cycle("R4", "R6");
    idle(); save_req = 1'b1; do_cycle("R4", "R6");
    idle(); rd_a_sel = 5'd25; rd_b_sel = 5'd9; do_cycle("R4", "R6");

    // R6: save and restore together -> save wins
    idle(); save_req = 1'b1; restore_req = 1'b1; do_cycle("", "R6");
    // R6 wrap up: restore twice returns through NW-1 to 0
    idle(); restore_req = 1'b1; do_cycle("", "R6");
    idle(); restore_req = 1'b1; do_cycle("", "R6");

    // R7 spill: mark window below, save blocked
    idle(); mask_load = 1'b1; mask_in = NW'(1) << ((mcwp + NW - 1) % NW); do_cycle("", "R9");
    idle(); save_req = 1'b1; do_cycle("", "R7");
    idle(); do_cycle("", "R7");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int rs;
      idle();
      rd_a_sel = 5'($urandom); rd_b_sel = 5'($urandom);
      wr_en = 1'($urandom); wr_sel = 5'($urandom); wr_data = $urandom;
      rs = int'($urandom % 10);
      save_req = (rs == 0) || (rs == 2);
      restore_req = (rs == 1) || (rs == 2);
      if ($urandom % 40 == 0) begin
        mask_load = 1'b1;
        mask_in = ($urandom % 4 == 0) ? '0 : NW'(1) << ($urandom % NW);
      end
      do_cycle("", "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule